// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block produces the serial clock of an SPI master from the main clock. The divide is done in two cascaded stages. A power-of-two prescaler divides the main clock by 2, 4, 8 or 16, chosen by a 2-bit `div_i` field. A half-period counter then counts prescaler ticks and toggles the serial clock every `brg_i + 1` ticks, chosen by a 6-bit `brg_i` field. The total divide is therefore `2 * (2 << div) * (brg + 1)`. It runs from 20 main cycles at the fastest legal setting to 2048 at the slowest.

The shift engine beside this block uses two single-cycle strobes. One marks the cycle in which the serial clock leaves its idle level (leading edge). The other marks the cycle in which it returns to idle (trailing edge). A polarity input selects the idle level. While the enable is low, both counters are held cleared and the serial clock rests at its idle level. Raising the enable always starts a clean, full half period. A divider field below the legal minimum of 4 is run as 4, and a status output flags that case.

Top module: `sclk_div_gen`

## Requirements
- R1: After reset, with `en_i` low, `sclk_o` equals `cpol_i`, `lead_o` and `trail_o` are 0.
- R2: While enabled, every half period of `sclk_o` lasts exactly H = `(2 << div_i) * (brg_eff + 1)` main-clock cycles, so high and low phases are equal (50% duty).
- R3: The full serial clock period is 2*H. `div_i`=0, `brg_i`=4 gives 20 cycles, and `div_i`=3, `brg_i`=63 gives 2048 cycles.
- R4: `brg_eff` equals `brg_i` when `brg_i` is 4 or more, and 4 otherwise. `brg_clamped_o` is 1 exactly when `brg_i` is below 4.
- R5: While `en_i` is low, `sclk_o` sits at `cpol_i` (idle level), in the cycle after `en_i` is seen low and on.
- R6: `lead_o` is high for exactly the one cycle in which `sclk_o` has just changed from `cpol_i` to `!cpol_i`. `trail_o` is high for exactly the one cycle in which `sclk_o` has just returned to `cpol_i`.
- R7: `lead_o` and `trail_o` are never high together. With `en_i` and `cpol_i` steady, every change of `sclk_o` carries exactly one strobe, and the two strobes alternate starting with `lead_o`.
- R8: After `en_i` rises, the first change of `sclk_o` becomes visible after the H-th rising main-clock edge, counting the first edge that samples `en_i` high as edge 1.
- R9: Dropping `en_i` in mid-period returns `sclk_o` to idle after the next edge with no strobe. A later enable again waits a full H before its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the divider; low holds counters cleared |
| div_i | input | 2 | Prescaler select, divide by 2 << div_i |
| brg_i | input | 6 | Half-period count select, legal 4..63 |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on leaving idle level |
| trail_o | output | 1 | One-cycle strobe on returning to idle level |
| brg_clamped_o | output | 1 | High while brg_i is below the legal minimum |

## Verification
A prescaler count or half-period count that goes wrong shows up as a half period of the wrong length. It is caught at the first serial clock change after enable, within one half period, and re-checked on each later edge. A phase register that goes out of step with the strobes gives a strobe in a cycle where the clock holds, or a leading strobe at the idle level, which is flagged in that same cycle. Counters that are not cleared on disable show up as a short first half period after the next enable.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int unsigned DIV_W_DEF   = 2;
  localparam int unsigned BRG_W_DEF   = 6;
  localparam int unsigned BRG_MIN_DEF = 4;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_ACTIVE = 1'b1
  } sclk_phase_e;
endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PRE_W   = 2 ** DIV_W;
  localparam int unsigned MAX_DIV = PRE_W - 1;

  logic [PRE_W-1:0] pre_cnt_q;
  logic [PRE_W-1:0] lim_m1;
  logic [DIV_W-1:0] shr;

  // terminal count (2 << div) - 1 without overflowing PRE_W bits
  assign shr    = DIV_W'(MAX_DIV) - div_i;
  assign lim_m1 = {PRE_W{1'b1}} >> shr;
  assign tick_o = en_i && (pre_cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_cnt_q <= '0;
    else if (!en_i)  pre_cnt_q <= '0;
    else if (tick_o) pre_cnt_q <= '0;
    else             pre_cnt_q <= pre_cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
  parameter int unsigned BRG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_eff_i,
  output logic             toggle_o
);
  logic [BRG_W-1:0] hcnt_q;

  // >= keeps a live shrink of brg from running the count past its limit
  assign toggle_o = tick_i && (hcnt_q >= brg_eff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hcnt_q <= '0;
    else if (!en_i)    hcnt_q <= '0;
    else if (toggle_o) hcnt_q <= '0;
    else if (tick_i)   hcnt_q <= hcnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_edge_stage.sv
module sclk_edge_stage
  import sclk_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic toggle_i,
  input  logic cpol_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  sclk_phase_e phase_q;
  logic        lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= toggle_i && (phase_q == PH_IDLE);
      trail_q <= toggle_i && (phase_q == PH_ACTIVE);
      if (toggle_i)
        phase_q <= (phase_q == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
    end
  end

  assign sclk_o  = (phase_q == PH_ACTIVE) ^ cpol_i;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
  import sclk_div_pkg::*;
#(
  parameter int unsigned DIV_W   = DIV_W_DEF,
  parameter int unsigned BRG_W   = BRG_W_DEF,
  parameter int unsigned BRG_MIN = BRG_MIN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             brg_clamped_o
);
  localparam logic [BRG_W-1:0] BRG_FLOOR = BRG_W'(BRG_MIN);

  logic             tick;
  logic             toggle;
  logic [BRG_W-1:0] brg_eff;

  assign brg_clamped_o = (brg_i < BRG_FLOOR);
  assign brg_eff       = brg_clamped_o ? BRG_FLOOR : brg_i;

  sclk_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  sclk_half_counter #(.BRG_W(BRG_W)) u_half (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .tick_i    (tick),
    .brg_eff_i (brg_eff),
    .toggle_o  (toggle)
  );

  sclk_edge_stage u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .toggle_i (toggle),
    .cpol_i   (cpol_i),
    .sclk_o   (sclk_o),
    .lead_o   (lead_o),
    .trail_o  (trail_o)
  );
endmodule

// File: rtl/sclk_div_gen_chk.sv
module sclk_div_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  p_lead_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |-> (sclk_o == !cpol_i));

  p_trail_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_o |-> (sclk_o == cpol_i));

  p_idle_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (sclk_o == cpol_i && !lead_o && !trail_o));

  p_change_has_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $stable(cpol_i) && (sclk_o != $past(sclk_o)))
      |-> (lead_o || trail_o));

  p_strobe_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |=> !(lead_o || trail_o));
endmodule

bind sclk_div_gen sclk_div_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .cpol_i  (cpol_i),
  .sclk_o  (sclk_o),
  .lead_o  (lead_o),
  .trail_o (trail_o)
);

// File: tb/tb_sclk_div_gen.sv
module tb_sclk_div_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] div_i = '0;
  logic [5:0] brg_i = 6'd4;
  logic       cpol_i = 1'b0;
  logic       sclk_o, lead_o, trail_o, brg_clamped_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  sclk_div_gen dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .div_i         (div_i),
    .brg_i         (brg_i),
    .cpol_i        (cpol_i),
    .sclk_o        (sclk_o),
    .lead_o        (lead_o),
    .trail_o       (trail_o),
    .brg_clamped_o (brg_clamped_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one posedge then sample at the following negedge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // cycles until sclk changes, checking strobes on every sampled cycle
  task automatic wait_change(output int n, output int strobe_err);
    logic prev;
    prev = sclk_o;
    n = 0;
    strobe_err = 0;
    for (int i = 0; i < 4000; i++) begin
      step();
      n++;
      if (sclk_o != prev) begin
        if (sclk_o != cpol_i && !(lead_o && !trail_o)) strobe_err++;
        if (sclk_o == cpol_i && !(trail_o && !lead_o)) strobe_err++;
        break;
      end
      if (lead_o || trail_o) strobe_err++;
    end
  endtask

  task automatic run_setting(input logic [1:0] d, input logic [5:0] b, input logic pol);
    int h, eff, n, serr, serr_tot;
    en_i   = 1'b0;
    div_i  = d;
    brg_i  = b;
    cpol_i = pol;
    step();
    check("R5 idle level", int'(sclk_o), int'(pol));
    eff = (b < 6'd4) ? 4 : int'(b);
    h   = (2 << d) * (eff + 1);
    check("R4 clamp flag", int'(brg_clamped_o), int'(b < 6'd4));
    en_i = 1'b1;
    serr_tot = 0;
    wait_change(n, serr);
    serr_tot += serr;
    check("R8 first edge latency", n, h);
    check("R6 lead at active level", int'(sclk_o), int'(!pol));
    for (int k = 0; k < 3; k++) begin
      wait_change(n, serr);
      serr_tot += serr;
      check("R2 half period", n, h);
    end
    check("R7 strobe per change", serr_tot, 0);
    en_i = 1'b0;
    step();
    check("R9 idle after disable", int'(sclk_o), int'(pol));
  endtask

  task automatic t_reset();
    check("R1 sclk at reset", int'(sclk_o), 0);
    check("R1 lead at reset", int'(lead_o), 0);
    check("R1 trail at reset", int'(trail_o), 0);
  endtask

  task automatic t_period(input logic [1:0] d, input logic [5:0] b, input int exp_full);
    int n1, n2, s;
    en_i  = 1'b0;
    div_i = d;
    brg_i = b;
    cpol_i = 1'b0;
    step();
    en_i = 1'b1;
    wait_change(n1, s);
    wait_change(n1, s);
    wait_change(n2, s);
    check("R3 full period", n1 + n2, exp_full);
    en_i = 1'b0;
    step();
  endtask

  task automatic t_abort();
    int n, s;
    en_i = 1'b0; div_i = 2'd0; brg_i = 6'd6; cpol_i = 1'b1;
    step();
    en_i = 1'b1;
    for (int i = 0; i < 9; i++) step();
    en_i = 1'b0;
    step();
    check("R9 idle mid-period", int'(sclk_o), 1);
    check("R9 no strobe on abort", int'(lead_o || trail_o), 0);
    en_i = 1'b1;
    wait_change(n, s);
    check("R9 full half period after re-enable", n, 14);
    en_i = 1'b0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    run_setting(2'd0, 6'd4, 1'b0);
    run_setting(2'd1, 6'd10, 1'b1);
    run_setting(2'd0, 6'd1, 1'b0);
    run_setting(2'd2, 6'd0, 1'b1);
    run_setting(2'd3, 6'd63, 1'b0);
    run_setting(2'd2, 6'd3, 1'b0);
    t_period(2'd0, 6'd4, 20);
    t_period(2'd3, 6'd63, 2048);
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule